// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control unit of a small 8-bit CPU. It holds the opcode register and the step counter. Every clock it drives a 16-bit control word to the datapath, along with a separate PC-load strobe that has already been qualified by the flags. The datapath registers, the ALU and the memory sit outside the block. The block only takes the byte on the data bus, the zero and carry flags, a clock and a synchronous reset.

Each instruction starts with a common fetch step. In that step the program counter addresses memory, a read is requested, the PC advances, and the data-bus byte is latched as the new opcode. The later steps come from a microcode store addressed by the opcode in the upper bits and the step number in the lower bits.

Every microword holds three things: a control word with one bit per datapath signal, an end-of-instruction bit that sends the counter back to step 0, and a flag-condition field. The end bit and the condition field are internal and are not driven out. Conditional jumps never branch inside the microcode. Instead, the microcode PC-load bit is ANDed with the chosen flag.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_i` is high at a clock edge, the step counter and the opcode register clear. In any cycle with `rst_i` high, `ctrl_o` and `pc_load_o` are zero. The first cycle after release is a fetch, even if the reset came in the middle of an instruction.
- R2: The first cycle of every instruction is a fetch. `ctrl_o` = 0x5000 (memory read plus PC increment, no bus driver), `pc_load_o` = 0, and the `data_i` byte present at that cycle's closing edge becomes the opcode.
- R3: Control word bit layout. Bit k (k=0..3) makes register k (A=0, B=1, C=2, D=3) drive the data bus. Bit 4+k makes register k latch the bus. Bit 8 enables the ALU result onto the bus. Bits 11:9 select the ALU function, with add = 000. Bit 12 requests a memory read. Bit 13 requests a memory write. Bit 14 increments the PC. Bit 15 is the raw PC-load request.
- R4: A move has opcode 0x10 | dst<<2 | src and lasts 3 cycles: fetch, then a transfer cycle with word (1<<src)|(1<<(4+dst)), then an all-zero end cycle.
- R5: An add has opcode 0x20 | dst<<2 | src, computes dst = dst + src, and lasts 5 cycles: fetch, then 1<<dst, then 1<<src, then 0x0100|(1<<(4+dst)) with function 000, then an all-zero end cycle.
- R6: Jump-if-zero has opcode 0x40 and lasts 5 cycles. The words are fetch, 0x5000 (low operand byte), 0x5000 (high operand byte), 0x8000, and then zero. In the 0x8000 cycle, `pc_load_o` equals `flag_z_i`. The instruction ends on schedule whether or not the load happens.
- R7: Jump-if-carry has opcode 0x41 and behaves like R6, except that `pc_load_o` follows `flag_c_i`.
- R8: No-op (0x00) and every opcode not listed above run as fetch followed by one all-zero end cycle.
- R9: In every cycle, at most one of the bus sources (bits 0 to 3 and bit 8) is asserted.
- R10: `pc_load_o` is zero in every cycle other than the load step of a conditional jump, whatever the flag inputs are.
- R11: `data_i` is sampled only during fetch. Changes to it in any other step leave the running instruction's sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | OPC_W | Data-bus byte, captured as the opcode during fetch |
| flag_z_i | input | 1 | Zero flag from the ALU flags register |
| flag_c_i | input | 1 | Carry flag from the ALU flags register |
| ctrl_o | output | 16 | Control word to the datapath |
| pc_load_o | output | 1 | PC-load strobe, qualified by the flags |

## Verification
The bench builds the block with its defaults: an 8-bit opcode and a 4-bit step counter. With these values every opcode family is decoded exactly as the requirements encode it, including undefined codes next to the jump opcodes and codes with high bits set. The longest instruction uses five of the sixteen steps, so the bench runs every instruction back to back to show that each end cycle returns the counter to a fetch. Both flag polarities are applied to each jump. The flags are also held high during instructions that are not jumps. A reset is placed mid-instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned CW_BITS   = 16;

    // control word bit positions
    localparam int unsigned B_DRV0    = 0;
    localparam int unsigned B_LAT0    = 4;
    localparam int unsigned B_ALU_OE  = 8;
    localparam int unsigned B_ALU_FN0 = 9;
    localparam int unsigned B_MRD     = 12;
    localparam int unsigned B_MWR     = 13;
    localparam int unsigned B_PCINC   = 14;
    localparam int unsigned B_PCLD    = 15;

    localparam logic [CW_BITS-1:0] CW_ONE   = CW_BITS'(1);
    localparam logic [CW_BITS-1:0] FETCH_CW = (CW_ONE << B_MRD) | (CW_ONE << B_PCINC);
    localparam logic [2:0]         ALU_ADD  = 3'b000;

    // opcode codes (8-bit view)
    localparam logic [7:0] OP_NOP  = 8'h00;
    localparam logic [3:0] FAM_MOV = 4'h1;
    localparam logic [3:0] FAM_ADD = 4'h2;
    localparam logic [7:0] OP_JZ   = 8'h40;
    localparam logic [7:0] OP_JC   = 8'h41;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'd0,
        COND_ZERO   = 2'd1,
        COND_CARRY  = 2'd2
    } cond_e;

    typedef struct packed {
        logic [CW_BITS-1:0] cw;
        logic               last;
        cond_e              cond;
    } uword_t;

endpackage

// File: rtl/useq_ucode.sv
module useq_ucode
    import useq_pkg::*;
#(
    parameter int unsigned OPC_W  = 8,
    parameter int unsigned STEP_W = 4
) (
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [STEP_W-1:0] step_i,
    output uword_t            uw_o
);

    localparam int unsigned HI_W = OPC_W - 4;

    logic [1:0]      dst;
    logic [1:0]      src;
    logic            is_mov;
    logic            is_add;
    logic            is_jz;
    logic            is_jc;
    logic [2:0]      fn_sel;

    assign dst    = opc_i[3:2];
    assign src    = opc_i[1:0];
    assign is_mov = (opc_i[OPC_W-1:4] == HI_W'(FAM_MOV));
    assign is_add = (opc_i[OPC_W-1:4] == HI_W'(FAM_ADD));
    assign is_jz  = (opc_i == OPC_W'(OP_JZ));
    assign is_jc  = (opc_i == OPC_W'(OP_JC));
    assign fn_sel = ALU_ADD;

    always_comb begin
        uw_o      = '0;
        uw_o.cond = COND_ALWAYS;
        if (step_i == '0) begin
            uw_o.cw = FETCH_CW;
        end else if (is_mov) begin
            if (step_i == STEP_W'(1)) begin
                uw_o.cw = (CW_ONE << (B_DRV0 + 32'(src))) | (CW_ONE << (B_LAT0 + 32'(dst)));
            end else begin
                uw_o.last = 1'b1;
            end
        end else if (is_add) begin
            if (step_i == STEP_W'(1)) begin
                uw_o.cw = CW_ONE << (B_DRV0 + 32'(dst));
            end else if (step_i == STEP_W'(2)) begin
                uw_o.cw = CW_ONE << (B_DRV0 + 32'(src));
            end else if (step_i == STEP_W'(3)) begin
                uw_o.cw = (CW_ONE << B_ALU_OE) | (CW_ONE << (B_LAT0 + 32'(dst)))
                        | (CW_BITS'(fn_sel) << B_ALU_FN0);
            end else begin
                uw_o.last = 1'b1;
            end
        end else if (is_jz || is_jc) begin
            if (step_i == STEP_W'(1) || step_i == STEP_W'(2)) begin
                uw_o.cw = FETCH_CW;
            end else if (step_i == STEP_W'(3)) begin
                uw_o.cw   = CW_ONE << B_PCLD;
                uw_o.cond = is_jz ? COND_ZERO : COND_CARRY;
            end else begin
                uw_o.last = 1'b1;
            end
        end else begin
            // no-op and every undefined code: end right after fetch
            uw_o.last = 1'b1;
        end
    end

endmodule

// File: rtl/useq_state.sv
module useq_state #(
    parameter int unsigned OPC_W  = 8,
    parameter int unsigned STEP_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [OPC_W-1:0]  data_i,
    input  logic              last_i,
    output logic [STEP_W-1:0] step_o,
    output logic [OPC_W-1:0]  ir_o
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [OPC_W-1:0]  ir;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.step == '0) begin
            st_d.ir = data_i;
        end
        if (last_i) begin
            st_d.step = '0;
        end else begin
            st_d.step = st_q.step + 1'b1;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign step_o = st_q.step;
    assign ir_o   = st_q.ir;

    // opcode may only change across a fetch edge
    p_ir_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.step != '0) |=> $stable(st_q.ir));

    // an end-of-instruction microword restarts at fetch
    p_restart_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        last_i |=> (st_q.step == '0));

endmodule

// File: rtl/useq_jgate.sv
module useq_jgate
    import useq_pkg::*;
(
    input  logic  load_req_i,
    input  cond_e cond_i,
    input  logic  flag_z_i,
    input  logic  flag_c_i,
    output logic  load_o
);

    always_comb begin
        case (cond_i)
            COND_ZERO:  load_o = load_req_i & flag_z_i;
            COND_CARRY: load_o = load_req_i & flag_c_i;
            default:    load_o = load_req_i;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int unsigned OPC_W  = 8,
    parameter int unsigned STEP_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [OPC_W-1:0]   data_i,
    input  logic               flag_z_i,
    input  logic               flag_c_i,
    output logic [CW_BITS-1:0] ctrl_o,
    output logic               pc_load_o
);

    logic [STEP_W-1:0] step;
    logic [OPC_W-1:0]  ir;
    uword_t            uw;
    logic              load_gated;

    useq_state #(.OPC_W(OPC_W), .STEP_W(STEP_W)) i_state (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .data_i (data_i),
        .last_i (uw.last),
        .step_o (step),
        .ir_o   (ir)
    );

    useq_ucode #(.OPC_W(OPC_W), .STEP_W(STEP_W)) i_ucode (
        .opc_i  (ir),
        .step_i (step),
        .uw_o   (uw)
    );

    useq_jgate i_jgate (
        .load_req_i (uw.cw[B_PCLD]),
        .cond_i     (uw.cond),
        .flag_z_i   (flag_z_i),
        .flag_c_i   (flag_c_i),
        .load_o     (load_gated)
    );

    assign ctrl_o    = rst_i ? '0 : uw.cw;
    assign pc_load_o = rst_i ? 1'b0 : load_gated;

    always_comb begin
        if (rst_i) begin
            p_quiet_r1: assert (ctrl_o == '0 && pc_load_o == 1'b0);
        end
    end

    p_one_driver_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({ctrl_o[B_ALU_OE], ctrl_o[B_DRV0 +: 4]}) <= 1);

    p_fetch_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (step == '0) |-> (ctrl_o == FETCH_CW && !pc_load_o));

    p_pcload_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_load_o |-> ((ir == OPC_W'(OP_JZ) && flag_z_i) || (ir == OPC_W'(OP_JC) && flag_c_i)));

endmodule

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  data;
    logic        z;
    logic        c;
    logic [15:0] ctrl;
    logic        pcl;

    always #2 clk = ~clk;   // 250 MHz

    useq_ctrl i_useq_ctrl (
        .clk_i     (clk),
        .rst_i     (rst),
        .data_i    (data),
        .flag_z_i  (z),
        .flag_c_i  (c),
        .ctrl_o    (ctrl),
        .pc_load_o (pcl)
    );

    logic [15:0] exp_cw_q[$];
    logic        exp_pl_q[$];
    string       exp_tag_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;

    // drive one cycle and queue what the outputs must be during it
    task automatic cyc(input logic r, input logic [7:0] d, input logic zf, input logic cf,
                       input logic [15:0] ecw, input logic epl, input string tag);
        @(negedge clk);
        rst = r; data = d; z = zf; c = cf;
        exp_cw_q.push_back(ecw);
        exp_pl_q.push_back(epl);
        exp_tag_q.push_back(tag);
    endtask

    // one whole instruction; non-fetch cycles drive noise on the bus (R11)
    task automatic run_op(input logic [7:0] op, input logic zf, input logic cf);
        logic [7:0]  nz;
        logic [1:0]  dst;
        logic [1:0]  src;
        nz  = ~op;
        dst = op[3:2];
        src = op[1:0];
        cyc(1'b0, op, zf, cf, 16'h5000, 1'b0, "R2 fetch");
        if (op[7:4] == 4'h1) begin
            cyc(1'b0, nz, zf, cf, (16'd1 << src) | (16'd1 << (4 + dst)), 1'b0, "R4 R3 R11 R10");
            cyc(1'b0, 8'h41, zf, cf, 16'h0000, 1'b0, "R4 end");
        end else if (op[7:4] == 4'h2) begin
            cyc(1'b0, nz, zf, cf, 16'd1 << dst, 1'b0, "R5 R3 R11");
            cyc(1'b0, 8'h40, zf, cf, 16'd1 << src, 1'b0, "R5 R3 R11");
            cyc(1'b0, nz, zf, cf, 16'h0100 | (16'd1 << (4 + dst)), 1'b0, "R5 R3");
            cyc(1'b0, nz, zf, cf, 16'h0000, 1'b0, "R5 end");
        end else if (op == 8'h40 || op == 8'h41) begin
            cyc(1'b0, nz, zf, cf, 16'h5000, 1'b0, "R6 R7 operand");
            cyc(1'b0, nz, zf, cf, 16'h5000, 1'b0, "R6 R7 operand");
            cyc(1'b0, nz, zf, cf, 16'h8000, (op == 8'h40) ? zf : cf,
                (op == 8'h40) ? "R6 load" : "R7 load");
            cyc(1'b0, nz, zf, cf, 16'h0000, 1'b0, "R6 R7 end");
        end else begin
            cyc(1'b0, 8'h10, zf, cf, 16'h0000, 1'b0, "R8 end");
        end
    endtask

    // monitor: compares every queued expectation one step after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_cw_q.size() > 0) begin
                logic [15:0] ecw;
                logic        epl;
                string       tag;
                ecw = exp_cw_q.pop_front();
                epl = exp_pl_q.pop_front();
                tag = exp_tag_q.pop_front();
                n_cmp++;
                if (ctrl !== ecw || pcl !== epl) begin
                    n_bad++;
                    $display("FAIL %s: ctrl=%h pc_load=%b expected ctrl=%h pc_load=%b",
                             tag, ctrl, pcl, ecw, epl);
                end
                // R9: single bus source in every cycle
                n_cmp++;
                if ($countones({ctrl[8], ctrl[3:0]}) > 1) begin
                    n_bad++;
                    $display("FAIL R9: bus sources=%0d expected at most 1",
                             $countones({ctrl[8], ctrl[3:0]}));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; data = 8'h10; z = 1'b1; c = 1'b1;
        // R1: outputs quiet while reset is held
        cyc(1'b1, 8'h10, 1'b1, 1'b1, 16'h0000, 1'b0, "R1 reset");
        cyc(1'b1, 8'h40, 1'b1, 1'b1, 16'h0000, 1'b0, "R1 reset");
        cyc(1'b1, 8'h41, 1'b1, 1'b1, 16'h0000, 1'b0, "R1 reset");

        // R4 moves, R10 with both flags high
        run_op(8'h11, 1'b1, 1'b1);   // A <- B
        run_op(8'h1E, 1'b1, 1'b1);   // D <- C
        run_op(8'h14, 1'b0, 1'b0);   // B <- A
        run_op(8'h1B, 1'b0, 1'b1);   // C <- D

        // R5 adds
        run_op(8'h21, 1'b1, 1'b0);   // A += B
        run_op(8'h2E, 1'b0, 1'b1);   // D += C
        run_op(8'h25, 1'b0, 1'b0);   // B += B

        // R6 / R7 jumps, both polarities
        run_op(8'h40, 1'b1, 1'b0);
        run_op(8'h40, 1'b0, 1'b1);
        run_op(8'h41, 1'b0, 1'b1);
        run_op(8'h41, 1'b1, 1'b0);

        // R8 no-op and undefined codes
        run_op(8'h00, 1'b1, 1'b1);
        run_op(8'hFF, 1'b1, 1'b1);
        run_op(8'h30, 1'b0, 1'b0);
        run_op(8'h42, 1'b1, 1'b1);
        run_op(8'h80, 1'b1, 1'b1);

        // R1: reset in the middle of an add, then a clean fetch
        cyc(1'b0, 8'h2E, 1'b0, 1'b0, 16'h5000, 1'b0, "R2 fetch");
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 16'h0008, 1'b0, "R5");
        cyc(1'b1, 8'h00, 1'b1, 1'b1, 16'h0000, 1'b0, "R1 mid-instruction");
        run_op(8'h12, 1'b0, 1'b0);
        run_op(8'h40, 1'b1, 1'b1);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule